// File: doc/BRIEF.md
# SPI Receive Byte Packer and FIFO

This block takes the byte stream delivered by a serial receive engine and packs it into 32-bit entries of a small receive FIFO. Four bytes make a full entry. When the engine marks the end of a receive request while a word is still incomplete, the bytes collected so far go into the FIFO as a partial entry. That entry carries a 3-bit count of its valid bytes, so software reading the FIFO knows how much of the word is real data.

A small control word holds an enable, a self-clearing flush command and a 6-bit interrupt threshold. The block reports the number of stored entries and raises a receive interrupt request once that number reaches the threshold. The read side shows the head entry and its byte count at all times and removes the entry on a read strobe. A push into a full FIFO is dropped and sets a sticky overflow flag.

Top module: `spi_rx_packer`

## Requirements
- R1: Four accepted bytes form one entry with byte count 4. The first received byte sits in bits [31:24] and the last in bits [7:0].
- R2: A partial entry of n bytes (1 to 3) holds the latest byte in bits [7:0] and the earliest in lane n-1. Lanes above n-1 read as zero.
- R3: Bits [30:28] of `rx_status` give the byte count of the head entry, with 4 encoded as 3'b100. They read 0 when the FIFO is empty, and `rd_data` then also reads 0. All other status bits are 0.
- R4: `fill_level` counts stored entries. A push raises it by one and a read of a non-empty FIFO lowers it by one. A push and a read in the same cycle leave it unchanged.
- R5: On `ctrl_wr`, `ctrl_wdata` bit 0 sets the enable, bit 1 requests a flush and bits [13:8] set the trigger level. `ctrl_rdata` returns enable in bit 0 and the trigger in bits [13:8]. Bit 1 always reads 0, and so do the remaining bits. Reset clears enable and trigger.
- R6: While the enable is 0, incoming bytes are ignored.
- R7: `rx_irq` is high exactly when the trigger level is non-zero and `fill_level` is at or above it.
- R8: A flush empties the FIFO, discards the partly assembled word and clears the overflow flag, all at the clock edge of the write. Bytes arriving in that same cycle are discarded.
- R9: A push into a full FIFO with no read in the same cycle is dropped, and `rx_overflow` is set. The flag stays set until a flush.
- R10: An end-of-request mark with no pending byte pushes nothing. A byte arriving in the same cycle as the end mark is included in the partial entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte_vld | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_req_end | input | 1 | End of receive request; flushes a partial word into the FIFO |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control write data |
| ctrl_rdata | output | 16 | Control readback |
| rd_en | input | 1 | Remove the head entry |
| rd_data | output | 32 | Head entry data |
| rx_status | output | 32 | Status word, head byte count in [30:28] |
| fill_level | output | 6 | Number of stored entries |
| rx_irq | output | 1 | Receive interrupt request |
| rx_overflow | output | 1 | Sticky overflow flag |

## Verification
The bench compares a running model against the outputs on every cycle. A wrong assembly count or shift in the packer shows as a bad `rd_data` or byte count on the very entry that follows. A pointer or counter fault shows in `fill_level` on the next edge and in the head data once the ring wraps. A missed drop or a lost flush shows at once in `rx_overflow` and `fill_level`. Directed cases cover the full-FIFO drop, flush during a partial word, and a byte that arrives together with the end mark.

// File: rtl/spi_rx_packer_pkg.sv
// Shared types and field positions for the receive byte packer.
package spi_rx_packer_pkg;
    localparam int LANES      = 4;
    localparam int CNT_W      = 3;
    localparam int EN_BIT     = 0;
    localparam int FLUSH_BIT  = 1;
    localparam int TRIG_LSB   = 8;
    localparam int STAT_CNT_LSB = 28;

    typedef struct packed {
        logic [CNT_W-1:0]   nbytes;
        logic [8*LANES-1:0] data;
    } rxp_entry_t;
endpackage

// File: rtl/spi_rx_packer_ctrl.sv
// Control word: holds enable and trigger level, decodes a self-clearing
// flush command. Assumes the trigger field fits below bit 16.
module spi_rx_packer_ctrl
    import spi_rx_packer_pkg::*;
#(
    parameter int FILL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [15:0]       wdata,
    output logic              enable,
    output logic [FILL_W-1:0] trig,
    output logic              flush,
    output logic [15:0]       rdata
);
    // Store enable and trigger on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            trig   <= '0;
        end else if (wr) begin
            enable <= wdata[EN_BIT];
            trig   <= wdata[TRIG_LSB +: FILL_W];
        end
    end

    // Flush is a command, never stored.
    assign flush = wr & wdata[FLUSH_BIT];

    // Readback of stored fields only.
    always_comb begin
        rdata = '0;
        rdata[EN_BIT] = enable;
        rdata[TRIG_LSB +: FILL_W] = trig;
    end
endmodule

// File: rtl/spi_rx_packer_asm.sv
// Byte assembler: shifts bytes into a word, earliest byte moving toward
// the top lane, and pushes on four bytes or at end of request.
// Assumes at most one byte per cycle.
module spi_rx_packer_asm
    import spi_rx_packer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       flush,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       req_end,
    output logic       push,
    output rxp_entry_t push_entry
);
    logic [8*LANES-1:0] acc_q, acc_d;
    logic [CNT_W-1:0]   n_q, n_d;

    // Next word and count including this cycle's byte.
    always_comb begin
        acc_d = acc_q;
        n_d   = n_q;
        if (byte_vld && enable) begin
            acc_d = {acc_q[8*LANES-9:0], byte_in};
            n_d   = n_q + 1'b1;
        end
    end

    // Push on a full word or on end of request with data pending.
    assign push = !flush && ((n_d == CNT_W'(LANES)) || (req_end && (n_d != '0)));
    assign push_entry.nbytes = n_d;
    assign push_entry.data   = acc_d;

    // Hold the partial word, clearing it on push or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || push) begin
            acc_q <= '0;
            n_q   <= '0;
        end else begin
            acc_q <= acc_d;
            n_q   <= n_d;
        end
    end

    AST_PENDING_BELOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        n_q < CNT_W'(LANES)); // R1
    AST_PUSH_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_entry.nbytes != '0 && push_entry.nbytes <= CNT_W'(LANES))); // R2
    AST_FLUSH_DROPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> n_q == '0); // R8
endmodule

// File: rtl/spi_rx_packer_fifo.sv
// Entry FIFO with fill count, drop-on-full and sticky overflow.
// Assumes DEPTH between 2 and 2**FILL_W-1.
module spi_rx_packer_fifo
    import spi_rx_packer_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int FILL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  rxp_entry_t        push_entry,
    input  logic              pop_req,
    output rxp_entry_t        head,
    output logic [FILL_W-1:0] fill,
    output logic              ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rxp_entry_t mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic empty, full, pop, accept;

    assign empty  = (fill == '0);
    assign full   = (fill == FILL_W'(DEPTH));
    assign pop    = pop_req && !empty;
    assign accept = push && (!full || pop);

    // Pointers, count and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
            ovf  <= 1'b0;
        end else begin
            if (accept) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop)    rp <= (rp == LAST) ? '0 : rp + 1'b1;
            fill <= fill + FILL_W'(accept) - FILL_W'(pop);
            if (push && !accept) ovf <= 1'b1;
        end
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (accept && !flush) mem[wp] <= push_entry;
    end

    // Head view, zero when empty.
    assign head = empty ? '0 : mem[rp];

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH)); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0 && !ovf)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf); // R9
    AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop_req && !flush) |=> (fill == FILL_W'(DEPTH) && ovf)); // R9
endmodule

// File: rtl/spi_rx_packer.sv
// Top: control word, byte assembler and entry FIFO with interrupt.
// Assumes one received byte per cycle at most.
module spi_rx_packer
    import spi_rx_packer_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int FILL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_byte_vld,
    input  logic [7:0]        rx_byte,
    input  logic              rx_req_end,
    input  logic              ctrl_wr,
    input  logic [15:0]       ctrl_wdata,
    output logic [15:0]       ctrl_rdata,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic [31:0]       rx_status,
    output logic [FILL_W-1:0] fill_level,
    output logic              rx_irq,
    output logic              rx_overflow
);
    logic              enable, flush, push;
    logic [FILL_W-1:0] trig;
    rxp_entry_t        push_entry, head;

    spi_rx_packer_ctrl #(.FILL_W(FILL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata),
        .enable(enable), .trig(trig), .flush(flush), .rdata(ctrl_rdata)
    );

    spi_rx_packer_asm u_asm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush),
        .byte_vld(rx_byte_vld), .byte_in(rx_byte), .req_end(rx_req_end),
        .push(push), .push_entry(push_entry)
    );

    spi_rx_packer_fifo #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
        .push_entry(push_entry), .pop_req(rd_en), .head(head),
        .fill(fill_level), .ovf(rx_overflow)
    );

    // Output views of the head entry and threshold interrupt.
    always_comb begin
        rd_data   = head.data;
        rx_status = '0;
        rx_status[STAT_CNT_LSB +: CNT_W] = head.nbytes;
        rx_irq    = (trig != '0) && (fill_level >= trig);
    end

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> fill_level != '0); // R7
    AST_EMPTY_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> rx_status == '0); // R3
endmodule

// File: tb/spi_rx_packer_tb.sv
module spi_rx_packer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic clk = 0, rst_n = 0;
    logic rx_byte_vld = 0, rx_req_end = 0, ctrl_wr = 0, rd_en = 0;
    logic [7:0] rx_byte = 0;
    logic [15:0] ctrl_wdata = 0, ctrl_rdata;
    logic [31:0] rd_data, rx_status;
    logic [5:0] fill_level;
    logic rx_irq, rx_overflow;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    logic [31:0] mq_data[$];
    int          mq_cnt[$];
    logic [31:0] m_acc = 0;
    int          m_n = 0;
    bit          m_en = 0, m_ovf = 0;
    int          m_trig = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_rx_packer #(.DEPTH(DEPTH), .FILL_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .rx_req_end(rx_req_end), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .rd_en(rd_en), .rd_data(rd_data),
        .rx_status(rx_status), .fill_level(fill_level), .rx_irq(rx_irq),
        .rx_overflow(rx_overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl();
        return {18'd0, 6'(m_trig), 7'd0, m_en};
    endfunction

    // Requirement-level model of one clock edge.
    task automatic model_step(input bit bv, input logic [7:0] b, input bit re,
                              input bit rd, input bit cw, input logic [15:0] cwd);
        if (cw && cwd[1]) begin
            mq_data.delete(); mq_cnt.delete();
            m_acc = 0; m_n = 0; m_ovf = 0;
        end else begin
            if (rd && mq_data.size() > 0) begin
                void'(mq_data.pop_front()); void'(mq_cnt.pop_front());
            end
            if (bv && m_en) begin
                m_acc = {m_acc[23:0], b};
                m_n++;
            end
            if (m_n == 4 || (re && m_n > 0)) begin
                if (mq_data.size() < DEPTH) begin
                    mq_data.push_back(m_acc); mq_cnt.push_back(m_n);
                end else m_ovf = 1;
                m_acc = 0; m_n = 0;
            end
        end
        if (cw) begin
            m_en = cwd[0];
            m_trig = int'(cwd[13:8]);
        end
    endtask

    task automatic compare_all();
        int sz = mq_data.size();
        chk("R4 fill", 32'(fill_level), 32'(sz));
        chk("R1/R2 data", rd_data, sz > 0 ? mq_data[0] : 32'd0);
        chk("R3 status", rx_status, sz > 0 ? (32'(mq_cnt[0]) << 28) : 32'd0);
        chk("R7 irq", 32'(rx_irq), 32'((m_trig != 0) && (sz >= m_trig)));
        chk("R9 overflow", 32'(rx_overflow), 32'(m_ovf));
        chk("R5 ctrl", 32'(ctrl_rdata), exp_ctrl());
    endtask

    task automatic cyc(input bit bv, input logic [7:0] b, input bit re,
                       input bit rd, input bit cw, input logic [15:0] cwd);
        @(negedge clk);
        rx_byte_vld = bv; rx_byte = b; rx_req_end = re;
        rd_en = rd; ctrl_wr = cw; ctrl_wdata = cwd;
        model_step(bv, b, re, rd, cw, cwd);
        @(posedge clk); #1;
        compare_all();
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // reset state
        chk("R5 reset ctrl", 32'(ctrl_rdata), 0);
        chk("R4 reset fill", 32'(fill_level), 0);
        chk("R3 reset status", rx_status, 0);
        chk("R9 reset ovf", 32'(rx_overflow), 0);

        // R6: disabled, bytes ignored
        cyc(1, 8'h55, 0, 0, 0, 0);
        cyc(1, 8'h66, 1, 0, 0, 0);
        chk("R6 ignored while disabled", 32'(fill_level), 0);

        // R5: enable, trig 2, flush bit not stored
        cyc(0, 0, 0, 0, 1, 16'h0203);
        chk("R5 readback", 32'(ctrl_rdata), 32'h0201);

        // R1 full word
        cyc(1, 8'h11, 0, 0, 0, 0); cyc(1, 8'h22, 0, 0, 0, 0);
        cyc(1, 8'h33, 0, 0, 0, 0); cyc(1, 8'h44, 0, 0, 0, 0);
        chk("R1 full word", rd_data, 32'h11223344);
        chk("R3 count four", 32'(rx_status[30:28]), 4);
        cyc(0, 0, 0, 1, 0, 0);
        // R2 partial, R10 byte with end mark
        cyc(1, 8'hAA, 0, 0, 0, 0); cyc(1, 8'hBB, 0, 0, 0, 0);
        cyc(1, 8'hCC, 1, 0, 0, 0);
        chk("R2 partial three", rd_data, 32'h00AABBCC);
        chk("R10 end with byte count", 32'(rx_status[30:28]), 3);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R10 bare end mark", 32'(fill_level), 1);
        cyc(1, 8'h5A, 1, 1, 0, 0);
        chk("R2 single byte", rd_data, 32'h0000005A);
        chk("R4 push with read", 32'(fill_level), 1);

        // R9 overflow
        for (int i = 0; i < 4 * (DEPTH + 1); i++) cyc(1, 8'(i), 0, 0, 0, 0);
        chk("R9 full held", 32'(fill_level), DEPTH);
        chk("R9 flag set", 32'(rx_overflow), 1);
        chk("R7 irq at full", 32'(rx_irq), 1);

        // R8 flush with partial word pending
        cyc(1, 8'h77, 0, 0, 0, 0);
        cyc(1, 8'h78, 0, 0, 1, 16'h0003);
        chk("R8 flush empties", 32'(fill_level), 0);
        chk("R8 flush clears ovf", 32'(rx_overflow), 0);
        cyc(1, 8'h01, 0, 0, 0, 0); cyc(1, 8'h02, 0, 0, 0, 0);
        cyc(1, 8'h03, 1, 0, 0, 0);
        chk("R8 partial discarded", rd_data, 32'h00010203);

        // constrained random
        for (int k = 0; k < 6000; k++) begin
            bit cw = ($urandom % 97) == 0;
            logic [15:0] cwd = 0;
            if (cw) begin
                cwd[0] = ($urandom % 5) != 0;
                cwd[1] = ($urandom % 4) == 0;
                cwd[13:8] = 6'($urandom % 10);
            end
            cyc(($urandom % 3) != 0, 8'($urandom), ($urandom % 7) == 0,
                ($urandom % 3) == 0, cw, cwd);
        end
        idle();

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule